// File: doc/BRIEF.md
# Shared Parameter Memory Page Guard

This block fronts a shared parameter memory used by four serial channels: three general serial channels and one synchronous serial port. Each channel owns a page of that memory, and the block keeps a table of page base addresses that is loaded with fixed defaults at reset. Software can move a page with an assign command. The block accepts the move only if the new base is aligned, the page fits inside the memory window, and the page does not collide with any other channel's page.

The block also keeps a transmitter state and a receiver state for each channel, and changes them in response to control commands. A graceful transmit stop does not take effect at once. It waits for the channel's frame-end strobe, and until then the transmitter counts as running.

Every host write is decoded to a page and to a half of that page. The lower half is the receive region and the upper half is the transmit region. A write lands only if the engine that owns that region is stopped. Any other write is dropped and reported with an error pulse. Host reads are never blocked.

Top module: `prm_page_ctrl`

## Requirements
- R1: After reset, channel 0 has base 0x8400 with a 256-byte page, channel 1 has 0x8600 with 256 bytes, channel 2 has 0x8000 with 256 bytes, and channel 3 has 0x8900 with 128 bytes. All transmitters and receivers are stopped, and both error outputs are low.
- R2: Every page base is a multiple of 64 bytes at all times. An assign command whose base has any of bits [5:0] set is rejected.
- R3: An assign command (op 7) is accepted only when three conditions all hold: the base is aligned; the page lies inside the window from 0x8000 up to, but not including, 0x9000; and the page shares no byte with another channel's page. An accepted base appears on `page_base` in the cycle after the command. A rejected command pulses `cmd_err` high for exactly that one cycle and leaves the table unchanged.
- R4: A read returns the stored word on `host_rdata` one cycle after `host_rd`, whatever the channel states are. Addresses outside the window read as zero.
- R5: A write to the upper half of a page (the transmit region) is stored only while that channel's transmitter is stopped.
- R6: Op 1 (immediate transmit stop) stops the transmitter in the next cycle. Op 3 (restart) sets it running in the next cycle.
- R7: Op 2 (graceful stop) leaves a running transmitter counted as running, and transmit-region writes stay blocked. The transmitter stops at the clock edge where that channel's `frame_end` is sampled high. A `frame_end` pulse while no graceful stop is pending has no effect.
- R8: A write to the lower half of a page (the receive region) is stored only while that channel's receiver is stopped. Op 4 starts the receiver and op 5 stops it.
- R9: Op 6 (close receive buffer) leaves the receiver state unchanged, so receive-region writes stay blocked after it.
- R10: A write that is refused, or that falls outside every page, leaves the memory unchanged. It pulses `host_wr_err` high for the single cycle after the write. Op 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 16 | Host byte address |
| host_wdata | input | 32 | Host write word |
| host_rdata | output | 32 | Read word, valid one cycle after host_rd |
| host_wr_err | output | 1 | One-cycle pulse for a refused write |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (0 to 7) |
| cmd_ch | input | 2 | Target channel |
| cmd_base | input | 16 | New page base for the assign command |
| cmd_err | output | 1 | One-cycle pulse for a rejected assign command |
| frame_end | input | 4 | Per-channel end-of-frame strobe |
| tx_run | output | 4 | Transmitter running, including while a graceful stop is pending |
| rx_run | output | 4 | Receiver running |
| page_base | output | 64 | Current page bases, channel 0 in the low 16 bits |

## Verification
The bench builds the block with its default parameters: four channels, a 4 KB window of 32-bit words, and the default page layout. That small layout makes a complete sweep of the window affordable. Every word address is written with all engines stopped. Each page is then swept at 16-byte steps under all four combinations of transmitter and receiver state, so both halves of every page are checked against both states. Candidate bases for two channels are stepped at 32-byte spacing from below the window to above it, which covers misaligned, out-of-window, overlapping and accepted moves. After the moves, write permission is checked again against the relocated pages.

// File: rtl/prm_pkg.sv
package prm_pkg;

  typedef enum logic [2:0] {
    OP_NOP        = 3'd0,
    OP_TX_STOP    = 3'd1,
    OP_TX_GRACE   = 3'd2,
    OP_TX_RESTART = 3'd3,
    OP_RX_ON      = 3'd4,
    OP_RX_OFF     = 3'd5,
    OP_RX_CLOSE   = 3'd6,
    OP_ASSIGN     = 3'd7
  } prm_op_e;

  typedef enum logic [1:0] {
    TX_OFF   = 2'd0,
    TX_ON    = 2'd1,
    TX_DRAIN = 2'd2
  } tx_state_e;

  localparam int unsigned ALIGN_BITS = 6;

endpackage

// File: rtl/prm_chan_state.sv
module prm_chan_state
  import prm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cmd_hit,
  input  prm_op_e   cmd_op,
  input  logic      frame_end,
  output tx_state_e tx_state,
  output logic      rx_on
);

  tx_state_e tx_q, tx_d;
  logic      rx_q, rx_d;

  always_comb begin
    tx_d = tx_q;
    rx_d = rx_q;
    if (tx_q == TX_DRAIN && frame_end) tx_d = TX_OFF;
    if (cmd_hit) begin
      case (cmd_op)
        OP_TX_STOP:    tx_d = TX_OFF;
        OP_TX_GRACE:   if (tx_q == TX_ON) tx_d = TX_DRAIN;
        OP_TX_RESTART: tx_d = TX_ON;
        OP_RX_ON:      rx_d = 1'b1;
        OP_RX_OFF:     rx_d = 1'b0;
        default:       ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= TX_OFF;
      rx_q <= 1'b0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end

  assign tx_state = tx_q;
  assign rx_on    = rx_q;

  p_stop_now_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && cmd_op == OP_TX_STOP) |=> tx_q == TX_OFF);
  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && cmd_op == OP_TX_RESTART) |=> tx_q == TX_ON);
  p_grace_waits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_q == TX_ON && cmd_hit && cmd_op == OP_TX_GRACE) |=> tx_q == TX_DRAIN);
  p_frame_end_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_q == TX_DRAIN && frame_end && !cmd_hit) |=> tx_q == TX_OFF);
  p_close_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && cmd_op == OP_RX_CLOSE) |=> $stable(rx_q));

endmodule

// File: rtl/prm_page_table.sv
module prm_page_table
  import prm_pkg::*;
#(
  parameter int unsigned NUM_CH    = 4,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned RAM_BASE  = 32'h8000,
  parameter int unsigned RAM_BYTES = 4096,
  parameter logic [NUM_CH*ADDR_W-1:0] DEF_BASE  = '0,
  parameter logic [NUM_CH*ADDR_W-1:0] PAGE_SIZE = '0,
  localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned WIDE = ADDR_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     asg_valid,
  input  logic [CH_W-1:0]          asg_ch,
  input  logic [ADDR_W-1:0]        asg_base,
  output logic [NUM_CH*ADDR_W-1:0] base_flat,
  output logic                     asg_err
);

  localparam logic [WIDE-1:0] WIN_LO = WIDE'(RAM_BASE);
  localparam logic [WIDE-1:0] WIN_HI = WIDE'(RAM_BASE + RAM_BYTES);

  logic [ADDR_W-1:0] base_q [NUM_CH];
  logic [ADDR_W-1:0] base_d [NUM_CH];
  logic              err_q, err_d;
  logic              fits;
  logic [WIDE-1:0]   new_lo, new_hi, oth_lo, oth_hi, sel_size;

  always_comb begin
    sel_size = '0;
    for (int j = 0; j < NUM_CH; j++)
      if (asg_ch == CH_W'(j)) sel_size = WIDE'(PAGE_SIZE[j*ADDR_W +: ADDR_W]);
    new_lo = WIDE'(asg_base);
    new_hi = new_lo + sel_size;
    fits = (asg_base[ALIGN_BITS-1:0] == '0) && (new_lo >= WIN_LO) && (new_hi <= WIN_HI);
    for (int j = 0; j < NUM_CH; j++) begin
      oth_lo = WIDE'(base_q[j]);
      oth_hi = oth_lo + WIDE'(PAGE_SIZE[j*ADDR_W +: ADDR_W]);
      if (asg_ch != CH_W'(j) && new_lo < oth_hi && oth_lo < new_hi) fits = 1'b0;
    end
    base_d = base_q;
    err_d  = 1'b0;
    if (asg_valid) begin
      if (fits) base_d[asg_ch] = asg_base;
      else      err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < NUM_CH; j++) base_q[j] <= DEF_BASE[j*ADDR_W +: ADDR_W];
      err_q <= 1'b0;
    end else begin
      base_q <= base_d;
      err_q  <= err_d;
    end
  end

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_out
      assign base_flat[g*ADDR_W +: ADDR_W] = base_q[g];
      p_base_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        base_q[g][ALIGN_BITS-1:0] == '0);
    end
  endgenerate

  assign asg_err = err_q;

  p_reject_keeps_table_r3: assert property (@(posedge clk) disable iff (!rst_n)
    asg_err |-> $stable(base_flat));

endmodule

// File: rtl/prm_addr_decode.sv
module prm_addr_decode #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = 16,
  parameter logic [NUM_CH*ADDR_W-1:0] PAGE_SIZE = '0,
  localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned WIDE = ADDR_W + 1
) (
  input  logic [ADDR_W-1:0]        addr,
  input  logic [NUM_CH*ADDR_W-1:0] base_flat,
  output logic                     hit,
  output logic [CH_W-1:0]          hit_ch,
  output logic                     upper
);

  logic [WIDE-1:0] a, lo, sz, hi;

  always_comb begin
    a      = WIDE'(addr);
    hit    = 1'b0;
    hit_ch = '0;
    upper  = 1'b0;
    for (int j = 0; j < NUM_CH; j++) begin
      lo = WIDE'(base_flat[j*ADDR_W +: ADDR_W]);
      sz = WIDE'(PAGE_SIZE[j*ADDR_W +: ADDR_W]);
      hi = lo + sz;
      if (a >= lo && a < hi) begin
        hit    = 1'b1;
        hit_ch = CH_W'(j);
        upper  = (a - lo) >= (sz >> 1);
      end
    end
  end

endmodule

// File: rtl/prm_ram.sv
module prm_ram #(
  parameter int unsigned WORDS  = 1024,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned AW = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [WORDS];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata_q <= '0;
    else if (re) rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/prm_page_ctrl.sv
module prm_page_ctrl
  import prm_pkg::*;
#(
  parameter int unsigned NUM_CH    = 4,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned RAM_BASE  = 32'h8000,
  parameter int unsigned RAM_BYTES = 4096,
  parameter logic [NUM_CH*ADDR_W-1:0] DEF_BASE  = {16'h8900, 16'h8000, 16'h8600, 16'h8400},
  parameter logic [NUM_CH*ADDR_W-1:0] PAGE_SIZE = {16'd128, 16'd256, 16'd256, 16'd256},
  localparam int unsigned CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned WORDS   = RAM_BYTES / (DATA_W / 8),
  localparam int unsigned WORD_AW = $clog2(WORDS),
  localparam int unsigned BYTE_SH = $clog2(DATA_W / 8)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     host_wr,
  input  logic                     host_rd,
  input  logic [ADDR_W-1:0]        host_addr,
  input  logic [DATA_W-1:0]        host_wdata,
  output logic [DATA_W-1:0]        host_rdata,
  output logic                     host_wr_err,
  input  logic                     cmd_valid,
  input  logic [2:0]               cmd_op,
  input  logic [CH_W-1:0]          cmd_ch,
  input  logic [ADDR_W-1:0]        cmd_base,
  output logic                     cmd_err,
  input  logic [NUM_CH-1:0]        frame_end,
  output logic [NUM_CH-1:0]        tx_run,
  output logic [NUM_CH-1:0]        rx_run,
  output logic [NUM_CH*ADDR_W-1:0] page_base
);

  localparam logic [ADDR_W:0] WIN_LO = (ADDR_W+1)'(RAM_BASE);
  localparam logic [ADDR_W:0] WIN_HI = (ADDR_W+1)'(RAM_BASE + RAM_BYTES);

  prm_op_e           op;
  logic [NUM_CH-1:0] tx_off;
  logic              dec_hit, dec_upper, wr_ok, in_win;
  logic [CH_W-1:0]   dec_ch;
  logic [ADDR_W-1:0] rel_addr;
  logic [WORD_AW-1:0] widx;
  logic [DATA_W-1:0] ram_q;
  logic              wr_err_q, wr_err_d, oob_q, oob_d;

  assign op = prm_op_e'(cmd_op);

  prm_page_table #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .RAM_BASE(RAM_BASE), .RAM_BYTES(RAM_BYTES),
    .DEF_BASE(DEF_BASE), .PAGE_SIZE(PAGE_SIZE)
  ) i_table (
    .clk(clk), .rst_n(rst_n),
    .asg_valid(cmd_valid && op == OP_ASSIGN),
    .asg_ch(cmd_ch), .asg_base(cmd_base),
    .base_flat(page_base), .asg_err(cmd_err)
  );

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
      tx_state_e st;
      prm_chan_state i_chan (
        .clk(clk), .rst_n(rst_n),
        .cmd_hit(cmd_valid && cmd_ch == CH_W'(g)),
        .cmd_op(op), .frame_end(frame_end[g]),
        .tx_state(st), .rx_on(rx_run[g])
      );
      assign tx_off[g] = (st == TX_OFF);
      assign tx_run[g] = (st != TX_OFF);
    end
  endgenerate

  prm_addr_decode #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .PAGE_SIZE(PAGE_SIZE)
  ) i_dec (
    .addr(host_addr), .base_flat(page_base),
    .hit(dec_hit), .hit_ch(dec_ch), .upper(dec_upper)
  );

  always_comb begin
    in_win   = ((ADDR_W+1)'(host_addr) >= WIN_LO) && ((ADDR_W+1)'(host_addr) < WIN_HI);
    rel_addr = host_addr - ADDR_W'(RAM_BASE);
    widx     = rel_addr[BYTE_SH +: WORD_AW];
    wr_ok    = dec_hit && (dec_upper ? tx_off[dec_ch] : !rx_run[dec_ch]);
    wr_err_d = host_wr && !wr_ok;
    oob_d    = host_rd ? !in_win : oob_q;
  end

  prm_ram #(.WORDS(WORDS), .DATA_W(DATA_W)) i_ram (
    .clk(clk), .rst_n(rst_n),
    .we(host_wr && wr_ok), .waddr(widx), .wdata(host_wdata),
    .re(host_rd && in_win), .raddr(widx), .rdata(ram_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_err_q <= 1'b0;
      oob_q    <= 1'b0;
    end else begin
      wr_err_q <= wr_err_d;
      oob_q    <= oob_d;
    end
  end

  assign host_wr_err = wr_err_q;
  assign host_rdata  = oob_q ? '0 : ram_q;

  p_wr_err_needs_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_err |-> $past(host_wr));
  p_tx_region_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && dec_hit && dec_upper && tx_run[dec_ch]) |=> host_wr_err);
  p_rx_region_guard_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && dec_hit && !dec_upper && rx_run[dec_ch]) |=> host_wr_err);

endmodule

// File: tb/test_prm_page_ctrl.sv
`timescale 1ns/1ps
module test_prm_page_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr, host_rd, cmd_valid;
  logic [15:0] host_addr, cmd_base;
  logic [31:0] host_wdata, host_rdata;
  logic        host_wr_err, cmd_err;
  logic [2:0]  cmd_op;
  logic [1:0]  cmd_ch;
  logic [3:0]  frame_end, tx_run, rx_run;
  logic [63:0] page_base;

  always #2.5 clk = ~clk;

  prm_page_ctrl i_prm_page_ctrl (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_wr_err(host_wr_err), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_ch(cmd_ch), .cmd_base(cmd_base), .cmd_err(cmd_err),
    .frame_end(frame_end), .tx_run(tx_run), .rx_run(rx_run), .page_base(page_base)
  );

  int n_chk = 0;
  int n_fail = 0;
  int exp_base [4] = '{'h8400, 'h8600, 'h8000, 'h8900};
  int psize    [4] = '{256, 256, 256, 128};
  int txs      [4];          // 0 stopped, 1 running, 2 graceful stop pending
  bit rxo      [4];
  logic [31:0] mem  [1024];
  bit          memv [1024];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int find_ch(input int a);
    for (int c = 0; c < 4; c++)
      if (a >= exp_base[c] && a < exp_base[c] + psize[c]) return c;
    return -1;
  endfunction

  function automatic bit is_upper(input int a);
    int c = find_ch(a);
    return (c >= 0) && (a - exp_base[c] >= psize[c] / 2);
  endfunction

  function automatic bit wr_allowed(input int a);
    int c = find_ch(a);
    if (c < 0) return 0;
    if (is_upper(a)) return txs[c] == 0;
    return !rxo[c];
  endfunction

  task automatic do_write(input int a, input logic [31:0] d);
    bit ok = wr_allowed(a);
    string req = (find_ch(a) < 0) ? "R10" : (is_upper(a) ? "R5" : "R8");
    @(negedge clk);
    host_wr = 1; host_addr = a[15:0]; host_wdata = d;
    @(negedge clk);
    host_wr = 0;
    check(host_wr_err == !ok, req, $sformatf("wr_err @%0h", a), host_wr_err, !ok);
    if (ok) begin
      mem[(a - 'h8000) >> 2]  = d;
      memv[(a - 'h8000) >> 2] = 1;
    end
  endtask

  task automatic do_read(input int a);
    @(negedge clk);
    host_rd = 1; host_addr = a[15:0];
    @(negedge clk);
    host_rd = 0;
    if (a < 'h8000 || a >= 'h9000)
      check(host_rdata == 0, "R4", $sformatf("oob read @%0h", a), host_rdata, 0);
    else if (memv[(a - 'h8000) >> 2])
      check(host_rdata == mem[(a - 'h8000) >> 2], "R4", $sformatf("read @%0h", a),
            host_rdata, mem[(a - 'h8000) >> 2]);
  endtask

  function automatic bit assign_ok(input int c, input int b);
    if (b % 64 != 0) return 0;
    if (b < 'h8000 || b + psize[c] > 'h9000) return 0;
    for (int j = 0; j < 4; j++)
      if (j != c && b < exp_base[j] + psize[j] && exp_base[j] < b + psize[c]) return 0;
    return 1;
  endfunction

  task automatic do_cmd(input int op, input int c, input int b);
    bit ok = 1;
    if (op == 7) ok = assign_ok(c, b);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op[2:0]; cmd_ch = c[1:0]; cmd_base = b[15:0];
    @(negedge clk);
    cmd_valid = 0;
    case (op)
      1: txs[c] = 0;
      2: if (txs[c] == 1) txs[c] = 2;
      3: txs[c] = 1;
      4: rxo[c] = 1;
      5: rxo[c] = 0;
      7: if (ok) exp_base[c] = b;
      default: ;
    endcase
    if (op == 7) begin
      check(cmd_err == !ok, (b % 64 != 0) ? "R2" : "R3",
            $sformatf("cmd_err ch%0d base %0h", c, b), cmd_err, !ok);
      check(page_base[c*16 +: 16] == exp_base[c][15:0], "R3", "page_base after assign",
            page_base[c*16 +: 16], exp_base[c]);
    end else begin
      check(cmd_err == 0, "R10", "cmd_err on control op", cmd_err, 0);
      check(tx_run[c] == (txs[c] != 0), (op == 2) ? "R7" : "R6",
            $sformatf("tx_run ch%0d op%0d", c, op), tx_run[c], txs[c] != 0);
      check(rx_run[c] == rxo[c], (op == 6) ? "R9" : "R8",
            $sformatf("rx_run ch%0d op%0d", c, op), rx_run[c], rxo[c]);
    end
  endtask

  task automatic pulse_fe(input int c);
    @(negedge clk);
    frame_end[c] = 1;
    @(negedge clk);
    frame_end[c] = 0;
    if (txs[c] == 2) txs[c] = 0;
    check(tx_run[c] == (txs[c] != 0), "R7", $sformatf("tx_run after frame_end ch%0d", c),
          tx_run[c], txs[c] != 0);
  endtask

  task automatic sweep_page(input int c, input int seed);
    for (int off = 0; off < psize[c]; off += 16) begin
      do_write(exp_base[c] + off, 32'(seed * 4096 + c * 512 + off));
      do_read(exp_base[c] + off);
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=expired expected=done");
    summary();
  end

  initial begin
    rst_n = 0; host_wr = 0; host_rd = 0; host_addr = 0; host_wdata = 0;
    cmd_valid = 0; cmd_op = 0; cmd_ch = 0; cmd_base = 0; frame_end = 0;
    for (int c = 0; c < 4; c++) begin txs[c] = 0; rxo[c] = 0; end
    for (int i = 0; i < 1024; i++) memv[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    for (int c = 0; c < 4; c++)
      check(page_base[c*16 +: 16] == exp_base[c][15:0], "R1", $sformatf("default base ch%0d", c),
            page_base[c*16 +: 16], exp_base[c]);
    check(tx_run == 0 && rx_run == 0, "R1", "engines stopped", {tx_run, rx_run}, 0);
    check(host_wr_err == 0 && cmd_err == 0, "R1", "errors low", {host_wr_err, cmd_err}, 0);

    // R5/R8/R10: whole window with everything stopped, then read every page word
    for (int a = 'h8000; a < 'h9000; a += 4) do_write(a, 32'(a * 3 + 1));
    for (int a = 'h8000; a < 'h9000; a += 4) if (find_ch(a) >= 0) do_read(a);
    do_read('h7FFC);
    do_read('h9000);

    // R10: refused-write pulse lasts one cycle and memory stays intact
    do_write('h8300, 32'hDEAD0001);
    @(negedge clk);
    check(host_wr_err == 0, "R10", "wr_err pulse width", host_wr_err, 0);
    do_cmd(0, 1, 0);

    // R4/R5/R6/R8: every tx/rx state combination on every page
    for (int combo = 0; combo < 4; combo++) begin
      for (int c = 0; c < 4; c++) begin
        do_cmd(combo[0] ? 3 : 1, c, 0);
        do_cmd(combo[1] ? 4 : 5, c, 0);
      end
      for (int c = 0; c < 4; c++) sweep_page(c, combo + 1);
    end

    // R7: graceful stop waits for frame_end
    for (int c = 0; c < 4; c++) begin
      do_cmd(3, c, 0);
      pulse_fe(c);                          // no pending stop: stays running
      do_cmd(2, c, 0);                      // pending: still counted running
      do_write(exp_base[c] + psize[c] - 4, 32'h6A6E0000 + c);
      do_read(exp_base[c] + psize[c] - 4);
      pulse_fe(c);
      do_write(exp_base[c] + psize[c] - 4, 32'h6A6E1000 + c);
      do_read(exp_base[c] + psize[c] - 4);
      do_cmd(2, c, 0);                      // graceful on stopped tx: stays stopped
    end
    do_cmd(3, 2, 0);
    do_cmd(2, 2, 0);
    do_cmd(1, 2, 0);                        // immediate stop overrides pending

    // R9: close-buffer keeps receiver running
    for (int c = 0; c < 4; c++) begin
      do_cmd(4, c, 0);
      do_cmd(6, c, 0);
      do_write(exp_base[c], 32'hC105E000 + c);
      do_read(exp_base[c]);
      do_cmd(5, c, 0);
      do_cmd(6, c, 0);
    end

    // R2/R3: base sweeps for two channels
    for (int b = 'h7F00; b <= 'h9100; b += 32) do_cmd(7, 3, b);
    for (int b = 'h7F00; b <= 'h9100; b += 32) do_cmd(7, 0, b);
    do_cmd(7, 1, exp_base[2]);              // direct collision
    for (int c = 0; c < 4; c++) sweep_page(c, 9);
    for (int a = 'h8000; a < 'h9000; a += 64) do_write(a, 32'(a));

    summary();
  end

endmodule